// File: doc/BRIEF.md
# Dual-Core Hardware Lock Bank

This block holds sixteen independent hardware locks that two processor cores use to share peripherals and memory regions. Each lock is a byte-wide location on a small memory-mapped access port; the lock at byte address n is lock n. A core takes a lock by writing the code that belongs to it and reading the location back. It holds the lock only when the read returns its own code. It gives the lock up by writing zero.

Each core has its own access port carrying address, write strobe, write data, read strobe and read data, plus the identity of the issuing master. The block resolves all claims in hardware. A claim takes effect only on a free lock, and only when its code matches the issuing master. A release takes effect only when it comes from the owner. When both cores claim the same free lock in one cycle, core 0 wins. Reads are registered and have no side effects.

Top module: `hw_lock_bank`

## Requirements
- R1: After reset every lock reads 0x00 and both read data outputs are 0x00.
- R2: Lock n is selected by address n (0 to 15), and a write to one lock never changes any other lock.
- R3: Core 0 (master id 0) claims a free lock by writing 0x01, and core 1 (master id 1) by writing 0x02. The lock then reads back that code.
- R4: A claim written to a lock that already reads 0x01 or 0x02 is ignored, and the lock keeps its owner.
- R5: A claim whose code does not match the issuing master is ignored: master id 0 writing 0x02, or master id 1 writing 0x01.
- R6: Writing 0x00 frees a lock only when the writer owns it. A 0x00 write from the other core is ignored.
- R7: Write values other than 0x00, 0x01 and 0x02 have no effect, and a lock only ever holds 0x00, 0x01 or 0x02.
- R8: If core 0 and core 1 both claim the same free lock in one cycle, the lock goes to core 0 (reads 0x01), whichever port each claim arrives on.
- R9: A read returns the addressed lock on read data one cycle later, with bits 7:2 zero. A read in the same cycle as a write returns the value from before that write. Reads change no lock, and read data holds its value while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_mid | input | 1 | Master id of the access on port A (0 = core 0, 1 = core 1) |
| a_addr | input | 4 | Lock address on port A |
| a_we | input | 1 | Write strobe on port A |
| a_wdata | input | 8 | Write data on port A |
| a_re | input | 1 | Read strobe on port A |
| a_rdata | output | 8 | Registered read data on port A |
| b_mid | input | 1 | Master id of the access on port B |
| b_addr | input | 4 | Lock address on port B |
| b_we | input | 1 | Write strobe on port B |
| b_wdata | input | 8 | Write data on port B |
| b_re | input | 1 | Read strobe on port B |
| b_rdata | output | 8 | Registered read data on port B |

## Verification
A write changes a lock at the clock edge where it is presented. A read presented at that same edge returns the old value, and a read presented one cycle later returns the new one. Every result reaches read data exactly one edge after its read strobe. The bench drives each access on a falling edge and computes the expected read values from its own lock model before applying that access's writes. It then compares both read data outputs at the next falling edge, so each sample lands one full register stage after the request. Cycles without a read check that read data held its last value.

// File: rtl/hw_lock_bank.sv
module hw_lock_bank #(
  parameter int NUM_GATES = 16,
  parameter int NUM_CORES = 2,
  parameter int DATA_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         a_mid,
  input  logic [$clog2(NUM_GATES)-1:0] a_addr,
  input  logic                         a_we,
  input  logic [DATA_W-1:0]            a_wdata,
  input  logic                         a_re,
  output logic [DATA_W-1:0]            a_rdata,
  input  logic                         b_mid,
  input  logic [$clog2(NUM_GATES)-1:0] b_addr,
  input  logic                         b_we,
  input  logic [DATA_W-1:0]            b_wdata,
  input  logic                         b_re,
  output logic [DATA_W-1:0]            b_rdata
);
  localparam int AW     = $clog2(NUM_GATES);
  localparam int CODE_W = $clog2(NUM_CORES + 1);

  logic [NUM_GATES-1:0][CODE_W-1:0] gate, gate_nxt;

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    logic hit_a, hit_b;
    logic [NUM_CORES-1:0] lock_req, rel_req;

    assign hit_a = a_we && (a_addr == AW'(g));
    assign hit_b = b_we && (b_addr == AW'(g));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assign lock_req[c] = (hit_a && (a_mid == 1'(c)) && (a_wdata == DATA_W'(c + 1)))
                        || (hit_b && (b_mid == 1'(c)) && (b_wdata == DATA_W'(c + 1)));
      assign rel_req[c]  = (hit_a && (a_mid == 1'(c)) && (a_wdata == '0))
                        || (hit_b && (b_mid == 1'(c)) && (b_wdata == '0));
    end

    always_comb begin
      gate_nxt[g] = gate[g];
      if (gate[g] == '0) begin
        for (int c = NUM_CORES - 1; c >= 0; c--)
          if (lock_req[c]) gate_nxt[g] = CODE_W'(c + 1);
      end else begin
        for (int c = 0; c < NUM_CORES; c++)
          if (gate[g] == CODE_W'(c + 1) && rel_req[c]) gate_nxt[g] = '0;
      end
    end

    assert_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      gate[g] <= CODE_W'(NUM_CORES));

    assert_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(gate[g]) != '0) |-> (gate[g] == $past(gate[g]) || gate[g] == '0));

    assert_foreign_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gate[g] == '0 && lock_req == '0) |=> gate[g] == '0);

    assert_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gate[g] == '0 && lock_req[0]) |=> gate[g] == CODE_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gate <= '0;
    else        gate <= gate_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_re) a_rdata <= DATA_W'(gate[a_addr]);
      if (b_re) b_rdata <= DATA_W'(gate[b_addr]);
    end
  end

  assert_rd_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    a_re |=> a_rdata == DATA_W'($past(gate[a_addr])));

  assert_rd_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    b_re |=> b_rdata == DATA_W'($past(gate[b_addr])));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !a_re |=> $stable(a_rdata));
endmodule

// File: tb/hw_lock_bank_tb.sv
`timescale 1ns/1ps
module hw_lock_bank_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic a_mid, a_we, a_re, b_mid, b_we, b_re;
  logic [3:0] a_addr, b_addr;
  logic [7:0] a_wdata, b_wdata, a_rdata, b_rdata;

  hw_lock_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_mid(a_mid), .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_re(a_re), .a_rdata(a_rdata),
    .b_mid(b_mid), .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_re(b_re), .b_rdata(b_rdata)
  );

  logic [7:0] model [16];
  logic [7:0] exp_a, exp_b;
  int checks = 0;
  int fails  = 0;

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // Each write is judged against the lock value at the start of the cycle.
  function automatic logic [7:0] next_lock(logic [7:0] old,
      logic aw, logic am, logic [7:0] ad, logic bw, logic bm, logic [7:0] bd);
    logic claim0, claim1, free0, free1;
    claim0 = (aw && !am && ad == 8'h01) || (bw && !bm && bd == 8'h01);
    claim1 = (aw &&  am && ad == 8'h02) || (bw &&  bm && bd == 8'h02);
    free0  = (aw && !am && ad == 8'h00) || (bw && !bm && bd == 8'h00);
    free1  = (aw &&  am && ad == 8'h00) || (bw &&  bm && bd == 8'h00);
    if (old == 8'h00) return claim0 ? 8'h01 : (claim1 ? 8'h02 : 8'h00);
    if (old == 8'h01 && free0) return 8'h00;
    if (old == 8'h02 && free1) return 8'h00;
    return old;
  endfunction

  task automatic step(string tag,
      logic aw, logic am, logic [3:0] aa, logic [7:0] ad, logic ar,
      logic bw, logic bm, logic [3:0] ba, logic [7:0] bd, logic br);
    logic [7:0] nm [16];
    a_we = aw; a_mid = am; a_addr = aa; a_wdata = ad; a_re = ar;
    b_we = bw; b_mid = bm; b_addr = ba; b_wdata = bd; b_re = br;
    if (ar) exp_a = model[aa];
    if (br) exp_b = model[ba];
    for (int g = 0; g < 16; g++)
      nm[g] = next_lock(model[g], aw && aa == 4'(g), am, ad, bw && ba == 4'(g), bm, bd);
    for (int g = 0; g < 16; g++) model[g] = nm[g];
    @(posedge clk);
    @(negedge clk);
    chk(tag, "port A read data", a_rdata, exp_a);
    chk(tag, "port B read data", b_rdata, exp_b);
    a_we = 0; a_re = 0; b_we = 0; b_re = 0;
  endtask

  task automatic wr(string tag, logic port_b, logic m, logic [3:0] ad, logic [7:0] d);
    if (port_b) step(tag, 0, 0, 0, 0, 0, 1, m, ad, d, 0);
    else        step(tag, 1, m, ad, d, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(string tag, logic [3:0] ad);
    step(tag, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1);
    step(tag, 0, 0, ad, 0, 1, 0, 0, ad, 0, 1);
  endtask

  task automatic rd_all(string tag);
    for (int g = 0; g < 16; g++) step(tag, 0, 0, 4'(g), 0, 1, 0, 0, 4'(15 - g), 0, 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(100000 * 5.0);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    for (int g = 0; g < 16; g++) model[g] = 8'h00;
    exp_a = 0; exp_b = 0;
    a_mid = 0; a_addr = 0; a_we = 0; a_wdata = 0; a_re = 0;
    b_mid = 0; b_addr = 0; b_we = 0; b_wdata = 0; b_re = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "A after reset", a_rdata, 8'h00);
    chk("R1", "B after reset", b_rdata, 8'h00);
    rst_n = 1;
    rd_all("R1");

    // R3 / R2: claim every lock, alternating cores and ports
    for (int g = 0; g < 16; g++) begin
      wr("R3", g[1], g[0], 4'(g), g[0] ? 8'h02 : 8'h01);
      rd("R3", 4'(g));
    end
    rd_all("R2");

    // R4: the other core tries to claim a held lock
    for (int g = 0; g < 16; g++) wr("R4", g[0], !g[0], 4'(g), g[0] ? 8'h01 : 8'h02);
    rd_all("R4");

    // R6: non-owner release ignored, owner release frees
    for (int g = 0; g < 16; g++) wr("R6", 0, !g[0], 4'(g), 8'h00);
    rd_all("R6");
    for (int g = 0; g < 16; g++) wr("R6", 1, g[0], 4'(g), 8'h00);
    rd_all("R6");

    // R5: code that does not match the master
    for (int g = 0; g < 16; g++) wr("R5", g[1], g[0], 4'(g), g[0] ? 8'h01 : 8'h02);
    rd_all("R5");

    // R7: every byte value from each core, then both cores release at once
    for (int v = 0; v < 256; v++)
      for (int m = 0; m < 2; m++) begin
        wr("R7", m[0], m[0], 4'd5, 8'(v));
        rd("R7", 4'd5);
        step("R7", 1, 0, 4'd5, 8'h00, 0, 1, 1, 4'd5, 8'h00, 0);
      end

    // R8: simultaneous claims, core 1 on port A and core 0 on port B; read in same cycle sees old value (R9)
    for (int g = 0; g < 16; g++) begin
      step("R8", 1, 1, 4'(g), 8'h02, 1, 1, 0, 4'(g), 8'h01, 1);
      rd("R8", 4'(g));
      wr("R8", 0, 0, 4'(g), 8'h00);
    end

    // R9: read data holds while idle
    wr("R9", 0, 1, 4'd3, 8'h02);
    rd("R9", 4'd3);
    repeat (4) step("R9", 0, 0, 4'd7, 0, 0, 0, 0, 4'd9, 0, 0);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] va, vb;
      va = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 3);
      vb = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 3);
      step("R2", 1'($urandom), 1'($urandom), 4'($urandom % 4), va, 1'($urandom),
                 1'($urandom), 1'($urandom), 4'($urandom % 4), vb, 1'($urandom));
    end
    rd_all("R2");

    summary();
  end
endmodule